// File: doc/BRIEF.md
# Edge-Kicked Watchdog and Reset Stretcher

This supervisor watches a software heartbeat and produces a clean processor reset. A divided clock supplies ticks to a loop counter. Every transition of the heartbeat input restarts the counter, whether it rises or falls. If no transition arrives within the timeout, the active-low watchdog output falls. It then stays low for a minimum hold time.

A one-shot stretcher turns any of three events into an active-high reset of fixed width: the power-up flag, a low level on the manual-reset input, or an undervoltage flag. Any new request while the reset is high starts the full width again. The undervoltage flag also drives a separate active-low power-fail output. While the reset is high, the watchdog counter is held at zero.

When the watchdog output is wired back to the manual-reset input, a hung program produces one reset pulse. The watchdog then clears itself and the cycle can repeat. All durations are parameters counted in prescaled ticks. The two asynchronous request inputs and the heartbeat input each pass through a synchronizer of `SYNC_STAGES` flops.

Top module: `wdt_supervisor`

## Requirements
- R1: While `pwr_up` is high, `cpu_rst` is 1, `wdog_n` is 1 and `pwr_fail_n` is 1. After `pwr_up` falls, `cpu_rst` stays high for exactly `PULSE_TICKS` ticks.
- R2: A low level on `man_rst_n` raises `cpu_rst` `SYNC_STAGES`+1 clocks later. After `man_rst_n` returns high, `cpu_rst` falls `SYNC_STAGES` clocks plus `PULSE_TICKS` ticks later.
- R3: A new reset request while `cpu_rst` is high restarts the full width. The fall is timed from the last request.
- R4: Rising and falling transitions of `kick_in` both restart the watchdog counter. Transitions spaced by any gap from 1 up to `TIMEOUT_TICKS` ticks never let `wdog_n` fall.
- R5: The counter restarts `SYNC_STAGES`+1 clocks after a `kick_in` transition. `wdog_n` falls exactly `TIMEOUT_TICKS` ticks after that restart if no further transition arrives.
- R6: Once `wdog_n` falls, it stays low for `HOLD_TICKS` ticks. If a transition has cleared the counter by then, it returns high after exactly `HOLD_TICKS` ticks.
- R7: With no transition and no reset, `wdog_n` stays low beyond the hold time. A later transition releases it `SYNC_STAGES`+1 clocks after that transition.
- R8: The watchdog counter is held at zero while `cpu_rst` is high. The next timeout falls `TIMEOUT_TICKS` ticks after `cpu_rst` falls.
- R9: With `wdog_n` looped to `man_rst_n` and no kicks, the block repeats a fixed cycle: a timeout, then a reset that starts `SYNC_STAGES`+1 clocks after `wdog_n` falls, then release of `wdog_n` after the hold time, then `cpu_rst` falling as in R2, then a fresh timeout.
- R10: A high `vlow` drives `pwr_fail_n` low `SYNC_STAGES` clocks later and keeps `cpu_rst` high. After `vlow` falls, `cpu_rst` is released as in R2 and `pwr_fail_n` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_up | input | 1 | Power-up flag, active high, asynchronous; also resets the block |
| kick_in | input | 1 | Heartbeat; any transition restarts the watchdog |
| man_rst_n | input | 1 | Manual reset request, active low, asynchronous |
| vlow | input | 1 | Undervoltage flag, active high, asynchronous |
| cpu_rst | output | 1 | Stretched processor reset, active high |
| wdog_n | output | 1 | Watchdog timeout, active low |
| pwr_fail_n | output | 1 | Power-fail indication, active low |

## Verification
The bench builds the block with `PRESCALE`=1, `TIMEOUT_TICKS`=12, `PULSE_TICKS`=9, `HOLD_TICKS`=7 and `SYNC_STAGES`=2. With these values one tick equals one clock, so every latency can be predicted to the exact cycle from the formulas. The timeout is short enough to sweep every kick gap from one tick up to the boundary. The whole loopback cycle (timeout, reset, hold release, pulse end, next timeout) also fits in a few dozen cycles and can be timed edge by edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   // bits needed to hold the values 0..n
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
   parameter int unsigned STAGES = 2,
   parameter bit          INIT   = 1'b0
) (
   input  logic clk,
   input  logic arst,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wdt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) chain <= {STAGES{INIT}};
      else      chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
   parameter int unsigned PRESCALE = 4
) (
   input  logic clk,
   input  logic arst,
   output logic tick
);
   localparam int unsigned PW = wdt_pkg::cnt_bits(PRESCALE - 1);
   localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

   if (PRESCALE < 2) begin : g_bad_div
      $error("wdt_prescale: PRESCALE must be at least 2");
   end

   logic [PW-1:0] div;

   always_ff @(posedge clk or posedge arst) begin
      if (arst)             div <= '0;
      else if (div == LAST) div <= '0;
      else                  div <= div + 1'b1;
   end

   assign tick = (div == LAST);
endmodule

// File: rtl/wdt_loop.sv
module wdt_loop #(
   parameter int unsigned TIMEOUT = 1600,
   parameter int unsigned HOLD    = 140,
   parameter int unsigned CW      = wdt_pkg::cnt_bits(TIMEOUT),
   parameter int unsigned HW      = wdt_pkg::cnt_bits(HOLD)
) (
   input  logic          clk,
   input  logic          arst,
   input  logic          tick,
   input  logic          kick,
   input  logic          clr,
   output logic          wdog_n,
   output logic [CW-1:0] cnt_o
);
   localparam logic [CW-1:0] TO_V  = CW'(TIMEOUT);
   localparam logic [CW-1:0] PRE_V = CW'(TIMEOUT - 1);
   localparam logic [HW-1:0] HLD_V = HW'(HOLD);

   logic [CW-1:0] cnt;
   logic [HW-1:0] hold;
   logic          restart;
   logic          expire;

   assign restart = clr | kick;
   assign expire  = tick & ~restart & (cnt == PRE_V);

   always_ff @(posedge clk or posedge arst) begin
      if (arst)                       cnt <= '0;
      else if (restart)               cnt <= '0;
      else if (tick && cnt != TO_V)   cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk or posedge arst) begin
      if (arst)                       hold <= '0;
      else if (expire)                hold <= HLD_V;
      else if (tick && hold != '0)    hold <= hold - 1'b1;
   end

   assign wdog_n = ~((cnt == TO_V) | (hold != '0));
   assign cnt_o  = cnt;
endmodule

// File: rtl/wdt_oneshot.sv
module wdt_oneshot #(
   parameter int unsigned WIDTH = 200,
   parameter int unsigned PW    = wdt_pkg::cnt_bits(WIDTH)
) (
   input  logic clk,
   input  logic arst,
   input  logic tick,
   input  logic trig,
   output logic active
);
   localparam logic [PW-1:0] FULL = PW'(WIDTH);

   logic [PW-1:0] remain;

   // power-up loads the full width so the pulse spans reset release
   always_ff @(posedge clk or posedge arst) begin
      if (arst)                        remain <= FULL;
      else if (trig)                   remain <= FULL;
      else if (tick && remain != '0)   remain <= remain - 1'b1;
   end

   assign active = (remain != '0);
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
   parameter int unsigned PRESCALE      = 50000,
   parameter int unsigned TIMEOUT_TICKS = 1600,
   parameter int unsigned PULSE_TICKS   = 200,
   parameter int unsigned HOLD_TICKS    = 140,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic pwr_up,
   input  logic kick_in,
   input  logic man_rst_n,
   input  logic vlow,
   output logic cpu_rst,
   output logic wdog_n,
   output logic pwr_fail_n
);
   localparam int unsigned CNT_W  = wdt_pkg::cnt_bits(TIMEOUT_TICKS);
   localparam int unsigned HOLD_W = wdt_pkg::cnt_bits(HOLD_TICKS);
   localparam int unsigned PLS_W  = wdt_pkg::cnt_bits(PULSE_TICKS);

   if (PRESCALE < 1) begin : g_bad_pre
      $error("wdt_supervisor: PRESCALE must be at least 1");
   end
   if (TIMEOUT_TICKS < 2) begin : g_bad_to
      $error("wdt_supervisor: TIMEOUT_TICKS must be at least 2");
   end
   if (PULSE_TICKS < 1) begin : g_bad_pulse
      $error("wdt_supervisor: PULSE_TICKS must be at least 1");
   end
   if (HOLD_TICKS <= SYNC_STAGES + 2) begin : g_bad_hold
      $error("wdt_supervisor: HOLD_TICKS must exceed SYNC_STAGES+2 so a looped reset can start");
   end

   logic tick;
   logic kick_s, kick_q, kick_edge;
   logic mr_s, lv_s;
   logic trig;
   logic [CNT_W-1:0] wd_cnt;

   // tick source: direct when undivided, counter otherwise
   if (PRESCALE == 1) begin : g_tick_direct
      assign tick = 1'b1;
   end else begin : g_tick_div
      wdt_prescale #(.PRESCALE(PRESCALE)) u_pre (
         .clk  (clk),
         .arst (pwr_up),
         .tick (tick)
      );
   end

   wdt_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_kick_sync (
      .clk (clk), .arst (pwr_up), .d (kick_in), .q (kick_s)
   );
   wdt_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_mr_sync (
      .clk (clk), .arst (pwr_up), .d (man_rst_n), .q (mr_s)
   );
   wdt_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_lv_sync (
      .clk (clk), .arst (pwr_up), .d (vlow), .q (lv_s)
   );

   // both polarities of heartbeat transition count as a kick
   always_ff @(posedge clk or posedge pwr_up) begin
      if (pwr_up) kick_q <= 1'b0;
      else        kick_q <= kick_s;
   end
   assign kick_edge = kick_s ^ kick_q;

   assign trig = ~mr_s | lv_s;

   wdt_oneshot #(.WIDTH(PULSE_TICKS), .PW(PLS_W)) u_pulse (
      .clk    (clk),
      .arst   (pwr_up),
      .tick   (tick),
      .trig   (trig),
      .active (cpu_rst)
   );

   wdt_loop #(
      .TIMEOUT (TIMEOUT_TICKS),
      .HOLD    (HOLD_TICKS),
      .CW      (CNT_W),
      .HW      (HOLD_W)
   ) u_loop (
      .clk    (clk),
      .arst   (pwr_up),
      .tick   (tick),
      .kick   (kick_edge),
      .clr    (cpu_rst),
      .wdog_n (wdog_n),
      .cnt_o  (wd_cnt)
   );

   assign pwr_fail_n = ~lv_s;
endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk #(
   parameter int unsigned TIMEOUT_TICKS = 1600,
   parameter int unsigned HOLD_TICKS    = 140,
   parameter int unsigned CNT_W         = 11
) (
   input logic             clk,
   input logic             pwr_up,
   input logic             tick,
   input logic             cpu_rst,
   input logic             wdog_n,
   input logic             pwr_fail_n,
   input logic [CNT_W-1:0] wd_cnt
);
   localparam int unsigned LW = wdt_pkg::cnt_bits(HOLD_TICKS);
   localparam logic [LW-1:0] HMAX = LW'(HOLD_TICKS);

   logic [LW-1:0] low_len;

   always_ff @(posedge clk or posedge pwr_up) begin
      if (pwr_up)                       low_len <= '0;
      else if (wdog_n)                  low_len <= '0;
      else if (tick && low_len != HMAX) low_len <= low_len + 1'b1;
   end

   // R8
   rst_holds_count_chk: assert property (@(posedge clk) disable iff (pwr_up)
      cpu_rst |=> (wd_cnt == '0));

   // R6
   min_low_time_chk: assert property (@(posedge clk) disable iff (pwr_up)
      $rose(wdog_n) |-> (low_len == HMAX));

   // R5
   trip_at_limit_chk: assert property (@(posedge clk) disable iff (pwr_up)
      $fell(wdog_n) |-> (wd_cnt == CNT_W'(TIMEOUT_TICKS)));

   // R7
   release_after_clear_chk: assert property (@(posedge clk) disable iff (pwr_up)
      $rose(wdog_n) |-> (wd_cnt != CNT_W'(TIMEOUT_TICKS)));

   // R10
   fail_forces_rst_chk: assert property (@(posedge clk) disable iff (pwr_up)
      !pwr_fail_n |=> cpu_rst);

   // R10
   no_release_in_fail_chk: assert property (@(posedge clk) disable iff (pwr_up)
      $fell(cpu_rst) |-> $past(pwr_fail_n));
endmodule

bind wdt_supervisor wdt_supervisor_chk #(
   .TIMEOUT_TICKS (TIMEOUT_TICKS),
   .HOLD_TICKS    (HOLD_TICKS),
   .CNT_W         (CNT_W)
) u_chk (
   .clk        (clk),
   .pwr_up     (pwr_up),
   .tick       (tick),
   .cpu_rst    (cpu_rst),
   .wdog_n     (wdog_n),
   .pwr_fail_n (pwr_fail_n),
   .wd_cnt     (wd_cnt)
);

// File: tb/sim_wdt_supervisor.sv
`timescale 1ns/1ps
module sim_wdt_supervisor;
   localparam int T = 12;
   localparam int P = 9;
   localparam int H = 7;
   localparam int S = 2;

   logic clk = 1'b0;
   logic pwr_up, kick_in, mr_drv, vlow, loop_en;
   logic man_rst_n, cpu_rst, wdog_n, pwr_fail_n;
   int   checks = 0;
   int   fails  = 0;

   always #2 clk = ~clk;

   assign man_rst_n = loop_en ? wdog_n : mr_drv;

   wdt_supervisor #(
      .PRESCALE(1), .TIMEOUT_TICKS(T), .PULSE_TICKS(P),
      .HOLD_TICKS(H), .SYNC_STAGES(S)
   ) u0 (
      .clk(clk), .pwr_up(pwr_up), .kick_in(kick_in), .man_rst_n(man_rst_n),
      .vlow(vlow), .cpu_rst(cpu_rst), .wdog_n(wdog_n), .pwr_fail_n(pwr_fail_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic pick(input int sel);
      case (sel)
         0:       return cpu_rst;
         1:       return wdog_n;
         default: return pwr_fail_n;
      endcase
   endfunction

   // negedges until the selected output reaches lvl (500 = never)
   task automatic wait_for(input int sel, input logic lvl, output int n);
      n = 0;
      while (n < 500) begin
         @(negedge clk);
         n++;
         if (pick(sel) == lvl) break;
      end
   endtask

   task automatic kick();
      kick_in = ~kick_in;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      int n;
      int tripped;
      pwr_up = 1'b1; kick_in = 1'b0; mr_drv = 1'b1; vlow = 1'b0; loop_en = 1'b0;
      repeat (5) @(negedge clk);
      // R1 reset state
      chk("R1 cpu_rst in power-up", int'(cpu_rst), 1);
      chk("R1 wdog_n in power-up", int'(wdog_n), 1);
      chk("R1 pwr_fail_n in power-up", int'(pwr_fail_n), 1);
      pwr_up = 1'b0;
      n = 0;
      while (cpu_rst && n < 500) begin n++; @(negedge clk); end
      chk("R1 power-up pulse width", n, P);
      // R8 counting starts when the reset ends
      wait_for(1, 1'b0, n);
      chk("R8 timeout after reset end", n, T);
      // R7 stays low without a kick
      repeat (H + 5) @(negedge clk);
      chk("R7 wdog_n still low", int'(wdog_n), 0);
      kick();
      wait_for(1, 1'b1, n);
      chk("R7 release after kick", n, S + 1);
      // R5 timeout measured from restart
      wait_for(1, 1'b0, n);
      chk("R5 timeout from restart", n, T);
      kick();
      wait_for(1, 1'b1, n);
      chk("R6 hold time", n, H);
      // R4 sweep kick gaps from 1 to T
      for (int gap = 1; gap <= T; gap++) begin
         tripped = 0;
         for (int r = 0; r < 4; r++) begin
            kick();
            for (int c = 0; c < gap; c++) begin
               @(negedge clk);
               if (!wdog_n) tripped = 1;
            end
         end
         chk($sformatf("R4 no trip at gap %0d", gap), tripped, 0);
      end
      // R5 exact timeout from a transition
      kick();
      wait_for(1, 1'b0, n);
      chk("R5 timeout from transition", n, T + S + 1);
      kick();
      wait_for(1, 1'b1, n);
      chk("R6 hold after prompt kick", n, H);
      // R2 manual reset
      kick();
      @(negedge clk);
      mr_drv = 1'b0;
      wait_for(0, 1'b1, n);
      chk("R2 reset rise latency", n, S + 1);
      repeat (4) @(negedge clk);
      mr_drv = 1'b1;
      wait_for(0, 1'b0, n);
      chk("R2 reset fall after release", n, P + S);
      kick();
      // R3 retrigger restarts the width
      @(negedge clk);
      mr_drv = 1'b0;
      @(negedge clk);
      mr_drv = 1'b1;
      repeat (5) @(negedge clk);
      chk("R3 reset active before retrigger", int'(cpu_rst), 1);
      mr_drv = 1'b0;
      @(negedge clk);
      mr_drv = 1'b1;
      wait_for(0, 1'b0, n);
      chk("R3 width from last request", n, P + S);
      kick();
      // R10 undervoltage
      @(negedge clk);
      vlow = 1'b1;
      wait_for(2, 1'b0, n);
      chk("R10 pwr_fail_n latency", n, S);
      repeat (3) @(negedge clk);
      chk("R10 reset during undervoltage", int'(cpu_rst), 1);
      repeat (20) @(negedge clk);
      chk("R10 reset held long undervoltage", int'(cpu_rst), 1);
      vlow = 1'b0;
      wait_for(0, 1'b0, n);
      chk("R10 reset fall after undervoltage", n, P + S);
      chk("R10 pwr_fail_n restored", int'(pwr_fail_n), 1);
      kick();
      // R9 looped watchdog to manual reset
      @(negedge clk);
      kick();
      loop_en = 1'b1;
      wait_for(1, 1'b0, n);
      chk("R9 loop timeout", n, T + S + 1);
      wait_for(0, 1'b1, n);
      chk("R9 loop reset start", n, S + 1);
      wait_for(1, 1'b1, n);
      chk("R9 loop wdog release", n, H - S - 1);
      wait_for(0, 1'b0, n);
      chk("R9 loop reset end", n, P + S);
      wait_for(1, 1'b0, n);
      chk("R9 R8 next timeout after reset", n, T);
      loop_en = 1'b0;
      kick();
      repeat (H + 5) @(negedge clk);
      chk("R9 wdog_n released after loop off", int'(wdog_n), 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule